// File: doc/BRIEF.md
# SPI Master Mode-Fault Controller

This block holds the configuration and mode-fault logic of an SPI peripheral. Software reaches it over a small register bus: a control register with the peripheral enable, a configuration lock and a software-driven slave-select level; a configuration register with the master select, slave-select source, output enable, polarity and fault-interrupt enable; a status register with a sticky mode-fault flag; and a write-one-to-clear register for that flag. Shifting data and generating the serial clock are handled elsewhere.

The block works out the effective slave-select level, taken either from the software level bit or from the external pin after two synchronizing flip-flops, and compares it with the configured polarity. Whenever the block is a master and that level is active, it records a mode fault. It then drops the master bit and the enable bit without software action, so a second master on the wire wins. Detection runs even while the peripheral is disabled. A master bit written while the slave-select level is already active therefore lasts one cycle only. While the fault flag is pending, no further demotion happens, so software that rewrites the master bit keeps it.

Top module: `spi_modefault_ctl`

## Requirements
- R1: After reset the control (address 0), configuration (address 1) and status (address 2) registers read 0 and `irq` is 0. A read returns its data on `bus_rdata` at the clock edge that samples `bus_rd`.
- R2: While enable and lock are both 0, a write to address 1 stores master at bit 22, software slave-select source at bit 26, slave-select output enable at bit 29, polarity at bit 28 and fault-interrupt enable at bit 0. Reads return those bits at the same positions.
- R3: A write to address 1 leaves the configuration unchanged while control bit 0 (enable) or control bit 1 (lock) is set.
- R4: When master is 1 and the effective slave-select level is active, the master bit returns to 0 and status bit 0 becomes 1 at the next clock edge. This also happens with enable at 0, so a master write that meets an active level reads back as 1 only for the one cycle after it lands.
- R5: With the source bit at 1 and polarity 0, setting control bit 2 (software level) to 1 before writing master 1 keeps the master bit at 1.
- R6: Status bit 0 holds until cleared. While it is set, no demotion takes place, and a master bit written again stays at 1.
- R7: Writing a word with bit 0 set to address 3 clears the fault flag. Writing one with bit 0 clear has no effect. If the fault condition still holds after the clear, the flag is set again and master is cleared one edge later.
- R8: `irq` is 1 exactly while the fault flag and the fault-interrupt enable are both set.
- R9: With the source bit at 0, the level comes from `ss_pin` through two flip-flops. A pin change becomes a demotion at the third clock edge after it.
- R10: With polarity 1, a high level is the active one. With polarity 0, a low level is the active one.
- R11: A mode fault also clears the enable bit in the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ss_pin | input | 1 | External slave-select pin |
| irq | output | 1 | Level interrupt for a pending mode fault |

## Verification
Suppose the block decides wrongly whether the level is active, or whether a fault is pending. That shows up as a master bit that either survives or disappears, readable at the second read after the write that set it. The enable bit and the status flag move at the same edge, and `irq` changes in the same cycle as the flag. A synchronizer of the wrong depth moves the demotion by one edge, so the bench reads the configuration in the exact cycle before the third edge after a pin change and again after that edge.

// File: rtl/spi_modefault_ctl.sv
module spi_modefault_ctl #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int MST_BIT     = 22,
  parameter int SRC_BIT     = 26,
  parameter int OE_BIT      = 29,
  parameter int POL_BIT     = 28,
  parameter int FIE_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ss_pin,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(3);

  logic en_q, lock_q, swlvl_q;
  logic mst_q, src_q, oe_q, pol_q, fie_q;
  logic fault_q;
  logic [SYNC_STAGES-1:0] pin_sync;

  wire cfg_open = !en_q && !lock_q;
  wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  wire wr_cfg   = bus_wr && (bus_addr == A_CFG) && cfg_open;
  wire wr_clr   = bus_wr && (bus_addr == A_FCLR) && bus_wdata[0];
  wire ss_level = src_q ? swlvl_q : pin_sync[SYNC_STAGES-1];
  wire ss_act   = (ss_level == pol_q);
  wire demote   = mst_q && ss_act && !fault_q;

  assign irq = fault_q && fie_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= '1;
    else        pin_sync <= {pin_sync[SYNC_STAGES-2:0], ss_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; lock_q <= 1'b0; swlvl_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata[0];
        lock_q  <= bus_wdata[1];
        swlvl_q <= bus_wdata[2];
      end
      if (demote) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0; src_q <= 1'b0; oe_q <= 1'b0; pol_q <= 1'b0; fie_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        mst_q <= bus_wdata[MST_BIT];
        src_q <= bus_wdata[SRC_BIT];
        oe_q  <= bus_wdata[OE_BIT];
        pol_q <= bus_wdata[POL_BIT];
        fie_q <= bus_wdata[FIE_BIT];
      end
      if (demote) mst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      fault_q <= 1'b0;
    else if (demote) fault_q <= 1'b1;
    else if (wr_clr) fault_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_CTRL: begin
          bus_rdata[0] <= en_q;
          bus_rdata[1] <= lock_q;
          bus_rdata[2] <= swlvl_q;
        end
        A_CFG: begin
          bus_rdata[MST_BIT] <= mst_q;
          bus_rdata[SRC_BIT] <= src_q;
          bus_rdata[OE_BIT]  <= oe_q;
          bus_rdata[POL_BIT] <= pol_q;
          bus_rdata[FIE_BIT] <= fie_q;
        end
        A_STAT:  bus_rdata[0] <= fault_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_demote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    demote |=> (!mst_q && fault_q));
  assert_enable_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    demote |=> !en_q);
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CFG && (en_q || lock_q) && !demote) |=>
      ($stable(mst_q) && $stable(src_q) && $stable(oe_q) && $stable(pol_q) && $stable(fie_q)));
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !(bus_wr && bus_addr == A_FCLR && bus_wdata[0])) |=> fault_q);
  assert_keep_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && mst_q && !(bus_wr && bus_addr == A_CFG)) |=> mst_q);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q |-> !irq);
endmodule

// File: tb/spi_modefault_ctl_test.sv
module spi_modefault_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ss_pin = 1'b1;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_modefault_ctl uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_pin(ss_pin), .irq(irq));

  function automatic logic [31:0] cfgw(bit mst, bit src, bit oe, bit pol, bit fie);
    cfgw = (32'(mst) << 22) | (32'(src) << 26) | (32'(oe) << 29) | (32'(pol) << 28) | 32'(fie);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(0, 0, "R1 ctrl reset");
    rd(1, 0, "R1 cfg reset");
    rd(2, 0, "R1 stat reset");
    check("R1 irq reset", 32'(irq), 0);

    // R2 field placement, no master yet
    wr(1, cfgw(0,1,1,0,1));
    rd(1, cfgw(0,1,1,0,1), "R2 cfg readback");

    // R5 software level high first, master stays
    wr(0, 32'h4);
    wr(1, cfgw(1,1,1,0,1));
    rd(1, cfgw(1,1,1,0,1), "R5 master kept");
    rd(1, cfgw(1,1,1,0,1), "R5 master kept later");
    rd(2, 0, "R5 no fault");

    // R3 locked and enabled writes ignored
    wr(0, 32'h6);
    wr(1, 0);
    rd(1, cfgw(1,1,1,0,1), "R3 ignored under lock");
    wr(0, 32'h5);
    wr(1, 0);
    rd(1, cfgw(1,1,1,0,1), "R3 ignored while enabled");

    // R4/R11 fault while enabled: level drops low
    wr(0, 32'h1);
    rd(0, 32'h1, "R11 enable before demotion");
    rd(1, cfgw(0,1,1,0,1), "R4 master demoted");
    rd(0, 32'h0, "R11 enable cleared");
    rd(2, 1, "R4 flag set");
    check("R8 irq with enable", 32'(irq), 1);

    // R6 pending flag blocks demotion
    wr(1, cfgw(1,1,0,0,1));
    rd(1, cfgw(1,1,0,0,1), "R6 second write kept");
    rd(1, cfgw(1,1,0,0,1), "R6 still kept");
    rd(2, 1, "R6 flag sticky");

    // R7 clear rules
    wr(3, 0);
    rd(2, 1, "R7 zero write ignored");
    wr(3, 1);
    rd(2, 0, "R7 flag cleared");
    rd(2, 1, "R7 flag re-set by live fault");
    rd(1, cfgw(0,1,0,0,1), "R7 master demoted after clear");
    wr(0, 32'h4);
    wr(3, 1);
    rd(2, 0, "R7 flag cleared for good");
    check("R8 irq low after clear", 32'(irq), 0);

    // R4 fault while disabled, R8 interrupt masked
    wr(1, cfgw(1,1,0,0,0));
    wr(0, 32'h0);
    rd(1, cfgw(1,1,0,0,0), "R4 master visible one cycle");
    rd(1, cfgw(0,1,0,0,0), "R4 demoted while disabled");
    rd(2, 1, "R4 flag while disabled");
    check("R8 irq masked", 32'(irq), 0);
    wr(3, 1);

    // R10 polarity high
    wr(1, cfgw(1,1,0,1,1));
    rd(1, cfgw(1,1,0,1,1), "R10 low level inactive");
    rd(1, cfgw(1,1,0,1,1), "R10 low level inactive later");
    wr(0, 32'h4);
    rd(1, cfgw(1,1,0,1,1), "R10 one cycle before demotion");
    rd(1, cfgw(0,1,0,1,1), "R10 high level demotes");
    rd(2, 1, "R10 flag");
    check("R8 irq polarity high", 32'(irq), 1);
    wr(3, 1);

    // R9 external pin through synchronizer
    wr(1, cfgw(1,0,0,0,0));
    rd(1, cfgw(1,0,0,0,0), "R9 pin high inactive");
    ss_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd(1, cfgw(1,0,0,0,0), "R9 still master before third edge");
    rd(1, cfgw(0,0,0,0,0), "R9 demoted at third edge");
    rd(2, 1, "R9 flag");
    wr(3, 1);
    rd(2, 0, "R9 flag cleared");
    ss_pin = 1'b1;

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard leftover", 32'(exp_q.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule